// File: doc/BRIEF.md
# Cascadable Serial Channel-Enable Port

This block is the serial command front end of a four-channel output controller. A host frames a transfer by pulling the select line low, then clocks command bits in on the data input while the block clocks per-channel fault flags out on the data output. The fault flags are snapshotted once, at the moment select goes low, and leave ahead of any command data. Several blocks can be chained, data output to the next data input, because the shift path behaves as a four-stage delay line: after its own four fault bits each block passes on what it received.

When select returns high, the four most recently received bits move into an enable latch that drives the channel enables, and the serial output stops driving. The serial clock, select, data input and fault vector are all brought into one system clock domain through synchronizer stages. Edges are detected there, so the serial clock must be well below the system clock.

Top module: `serial_chan_ctrl`

## Requirements
- R1: While reset is low, and after it rises until the first completed frame, every channel enable is 0 and the output-enable of the serial output is 0.
- R2: The serial output is driven (output-enable 1) only while a frame is open; within a few system cycles of select rising, output-enable returns to 0.
- R3: At the select falling edge the fault vector is captured, and the serial output presents fault bit 3 before the first serial clock edge.
- R4: On each falling serial clock edge the serial output advances, so the fault bits leave in the order 3, 2, 1, 0 (a 1 marks a faulted channel).
- R5: Fault inputs that change while select is low do not alter the bits shifted out in that frame.
- R6: The data input is sampled on each rising serial clock edge and reappears on the serial output four serial clocks later, after the fault bits.
- R7: At the select rising edge the last four received bits load the enable latch; the first of those four drives channel 3 and the last drives channel 0, and a 1 enables its channel.
- R8: If a frame has fewer than four serial clocks, the latch still loads the register as it stands: the remaining fault bits in the upper positions, the received bits below them.
- R9: Serial clock edges while select is high change neither the enables nor the output-enable.
- R10: A rising serial clock edge that lands in the same synchronized cycle as the select rising edge is not shifted in; the latch gets the register as it was before that edge.
- R11: A rising serial clock edge in the same synchronized cycle as the select falling edge is ignored; the fault snapshot is kept whole.
- R12: The channel enables change only at a select rising edge and hold through the whole of a following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_sel_n | input | 1 | Frame select, active low |
| ser_din | input | 1 | Serial command data in |
| chan_fault | input | 4 | Per-channel fault flags, 1 = fault |
| ser_dout | output | 1 | Serial fault/pass-through data out |
| ser_dout_en | output | 1 | Drive enable for the serial output pad; pad is high impedance when 0 |
| chan_en | output | 4 | Latched channel enables, bit 3 = first bit of the final four |

## Verification
Select edges and serial clock edges share one synchronizer, so a select transition and a serial clock transition driven in the same system cycle reach the edge detectors in the same cycle. The bench provokes this at both frame boundaries: it raises select together with a serial clock rise and checks that the latch holds the pre-edge register, and it drops select together with a serial clock rise and checks, on the output after the next falling serial edge, that fault bit 3 is still at the head of the register rather than having been shifted away.

// File: rtl/serial_chan_pkg.sv
package serial_chan_pkg;
  localparam int unsigned CHANNELS = 4;
  localparam int unsigned SYNC_STAGES = 2;

  // Shift the register one place toward the output end, new bit at the bottom.
  function automatic logic [CHANNELS-1:0] shift_in(input logic [CHANNELS-1:0] cur,
                                                   input logic bit_in);
    return {cur[CHANNELS-2:0], bit_in};
  endfunction

  // Bit presented on the serial output: the top of the register.
  function automatic logic head_bit(input logic [CHANNELS-1:0] cur);
    return cur[CHANNELS-1];
  endfunction
endpackage

// File: rtl/level_sync.sv
module level_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{IDLE[b]}};
      else        pipe <= {pipe[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = pipe[STAGES-1];
  end
endmodule

// File: rtl/edge_detect.sv
module edge_detect #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= level;
  end
  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import serial_chan_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_active,
  input  logic                load_faults,
  input  logic                shift_now,
  input  logic                drive_now,
  input  logic                frame_close,
  input  logic                din,
  input  logic [CHANNELS-1:0] faults,
  output logic [CHANNELS-1:0] shreg,
  output logic                dout,
  output logic                dout_en
);
  logic do_shift;
  logic do_drive;

  // The snapshot at frame start outranks any serial edge in the same cycle.
  assign do_shift = shift_now & frame_active & ~load_faults;
  assign do_drive = drive_now & frame_active & ~load_faults;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           shreg <= '0;
    else if (load_faults) shreg <= faults;
    else if (do_shift)    shreg <= shift_in(shreg, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dout <= 1'b0;
    else if (load_faults) dout <= head_bit(faults);
    else if (do_drive)    dout <= head_bit(shreg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dout_en <= 1'b0;
    else if (load_faults) dout_en <= 1'b1;
    else if (frame_close) dout_en <= 1'b0;
  end
endmodule

// File: rtl/enable_latch.sv
module enable_latch
  import serial_chan_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_close,
  input  logic [CHANNELS-1:0] shreg,
  output logic [CHANNELS-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           en <= '0;
    else if (frame_close) en <= shreg;
  end
endmodule

// File: rtl/serial_chan_ctrl.sv
module serial_chan_ctrl
  import serial_chan_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_clk,
  input  logic                ser_sel_n,
  input  logic                ser_din,
  input  logic [CHANNELS-1:0] chan_fault,
  output logic                ser_dout,
  output logic                ser_dout_en,
  output logic [CHANNELS-1:0] chan_en
);
  localparam int unsigned SW = CHANNELS + 3;
  localparam logic [SW-1:0] SYNC_IDLE = {1'b0, 1'b1, {(SW-2){1'b0}}};

  logic [SW-1:0]       raw_in;
  logic [SW-1:0]       sync_lv;
  logic                sclk_s;
  logic                sel_n_s;
  logic                din_s;
  logic [CHANNELS-1:0] fault_s;
  logic [1:0]          ctl_rise;
  logic [1:0]          ctl_fall;

  // Named events for the checker.
  logic                ev_sclk_rise;
  logic                ev_sclk_fall;
  logic                ev_sel_rise;
  logic                ev_sel_fall;
  logic                frame_active;
  logic [CHANNELS-1:0] shreg;

  assign raw_in = {ser_clk, ser_sel_n, ser_din, chan_fault};

  level_sync #(.W(SW), .STAGES(SYNC_STAGES), .IDLE(SYNC_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_in), .sync_out(sync_lv)
  );

  assign {sclk_s, sel_n_s, din_s, fault_s} = sync_lv;

  edge_detect #(.W(2), .IDLE(2'b01)) u_edges (
    .clk(clk), .rst_n(rst_n), .level({sclk_s, sel_n_s}),
    .rise(ctl_rise), .fall(ctl_fall)
  );

  assign ev_sclk_rise = ctl_rise[1];
  assign ev_sclk_fall = ctl_fall[1];
  assign ev_sel_rise  = ctl_rise[0];
  assign ev_sel_fall  = ctl_fall[0];
  assign frame_active = ~sel_n_s;

  frame_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .frame_active(frame_active),
    .load_faults(ev_sel_fall), .shift_now(ev_sclk_rise), .drive_now(ev_sclk_fall),
    .frame_close(ev_sel_rise), .din(din_s), .faults(fault_s),
    .shreg(shreg), .dout(ser_dout), .dout_en(ser_dout_en)
  );

  enable_latch u_latch (
    .clk(clk), .rst_n(rst_n), .frame_close(ev_sel_rise), .shreg(shreg), .en(chan_en)
  );
endmodule

// File: rtl/serial_chan_ctrl_chk.sv
module serial_chan_ctrl_chk
  import serial_chan_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                ev_sel_rise,
  input logic                ev_sel_fall,
  input logic                ev_sclk_rise,
  input logic                frame_active,
  input logic                din_s,
  input logic [CHANNELS-1:0] fault_s,
  input logic [CHANNELS-1:0] shreg,
  input logic [CHANNELS-1:0] chan_en,
  input logic                ser_dout_en
);
  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> (chan_en == '0 && !ser_dout_en));
  a_r2_release_stops_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sel_rise |=> !ser_dout_en);
  a_r3_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sel_fall |=> (shreg == $past(fault_s) && ser_dout_en));
  a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sclk_rise && frame_active && !ev_sel_fall) |=> shreg == {$past(shreg[CHANNELS-2:0]), $past(din_s)});
  a_r7_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sel_rise |=> chan_en == $past(shreg));
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_sel_rise |=> $stable(chan_en));
  a_r9_idle_static: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_active && !ev_sel_rise) |=> $stable(shreg));
endmodule

bind serial_chan_ctrl serial_chan_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_sel_rise(ev_sel_rise), .ev_sel_fall(ev_sel_fall),
  .ev_sclk_rise(ev_sclk_rise), .frame_active(frame_active), .din_s(din_s),
  .fault_s(fault_s), .shreg(shreg), .chan_en(chan_en), .ser_dout_en(ser_dout_en)
);

// File: tb/serial_chan_ctrl_tb.sv
module serial_chan_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_sel_n = 1'b1;
  logic       ser_din = 1'b0;
  logic [3:0] chan_fault = 4'b0000;
  logic       ser_dout;
  logic       ser_dout_en;
  logic [3:0] chan_en;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  serial_chan_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
    .ser_din(ser_din), .chan_fault(chan_fault), .ser_dout(ser_dout),
    .ser_dout_en(ser_dout_en), .chan_en(chan_en)
  );

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sel_low();
    ser_sel_n = 1'b0;
    wait_clk(6);
  endtask

  task automatic sel_high();
    ser_sel_n = 1'b1;
    wait_clk(6);
  endtask

  // One full serial clock; returns serial output seen after the falling edge.
  task automatic bit_clk(input logic b, output logic seen);
    ser_din = b;
    wait_clk(2);
    ser_clk = 1'b1;
    wait_clk(5);
    ser_clk = 1'b0;
    wait_clk(5);
    seen = ser_dout;
  endtask

  task automatic t_reset();
    check("R1 enables", {4'b0, chan_en}, 8'h00);
    check("R1 dout_en", {7'b0, ser_dout_en}, 8'h00);
  endtask

  task automatic t_readout_passthru();
    logic [7:0] data;
    logic       s;
    data = 8'b1100_1011; // sent bit 7 first
    chan_fault = 4'b1010;
    wait_clk(4);
    sel_low();
    check("R2 driven in frame", {7'b0, ser_dout_en}, 8'h01);
    check("R3 first bit is fault3", {7'b0, ser_dout}, 8'h01);
    for (int i = 0; i < 8; i++) begin
      bit_clk(data[7-i], s);
      if (i < 3) check("R4 fault order", {7'b0, s}, {7'b0, chan_fault[2-i]});
      else       check("R6 passthrough", {7'b0, s}, {7'b0, data[7-(i-3)]});
    end
    sel_high();
    check("R7 last four bits latched", {4'b0, chan_en}, 8'h0B);
    check("R2 released", {7'b0, ser_dout_en}, 8'h00);
  endtask

  task automatic t_late_fault();
    logic s;
    chan_fault = 4'b0000;
    wait_clk(4);
    sel_low();
    chan_fault = 4'b1111;
    wait_clk(4);
    check("R5 head unchanged", {7'b0, ser_dout}, 8'h00);
    check("R12 enables hold in frame", {4'b0, chan_en}, 8'h0B);
    for (int i = 0; i < 4; i++) begin
      bit_clk(1'b0, s);
      if (i < 3) check("R5 late fault not shifted", {7'b0, s}, 8'h00);
    end
    sel_high();
    check("R7 zeros latched", {4'b0, chan_en}, 8'h00);
  endtask

  task automatic t_short_frame();
    logic s;
    chan_fault = 4'b0110;
    wait_clk(4);
    sel_low();
    bit_clk(1'b1, s);
    bit_clk(1'b0, s);
    sel_high();
    check("R8 short frame", {4'b0, chan_en}, 8'h0A);
  endtask

  task automatic t_idle_clocks();
    logic s;
    for (int i = 0; i < 5; i++) bit_clk(1'b1, s);
    check("R9 enables unchanged", {4'b0, chan_en}, 8'h0A);
    check("R9 dout not driven", {7'b0, ser_dout_en}, 8'h00);
  endtask

  task automatic t_close_collision();
    logic s;
    chan_fault = 4'b0000;
    wait_clk(4);
    sel_low();
    bit_clk(1'b0, s);
    bit_clk(1'b1, s);
    bit_clk(1'b0, s);
    bit_clk(1'b1, s);
    ser_din = 1'b1;
    wait_clk(3);
    ser_sel_n = 1'b1;
    ser_clk = 1'b1;
    wait_clk(6);
    ser_clk = 1'b0;
    wait_clk(4);
    check("R10 close edge not shifted", {4'b0, chan_en}, 8'h05);
  endtask

  task automatic t_open_collision();
    logic s;
    chan_fault = 4'b1001;
    ser_din = 1'b0;
    wait_clk(4);
    ser_sel_n = 1'b0;
    ser_clk = 1'b1;
    wait_clk(6);
    check("R11 head after open", {7'b0, ser_dout}, 8'h01);
    ser_clk = 1'b0;
    wait_clk(5);
    check("R11 open edge not shifted", {7'b0, ser_dout}, 8'h01);
    bit_clk(1'b0, s);
    check("R11 next fault bit", {7'b0, s}, 8'h00);
    sel_high();
    check("R8 partial after collision", {4'b0, chan_en}, 8'h02);
  endtask

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_readout_passthru();
    t_late_fault();
    t_short_frame();
    t_idle_clocks();
    t_close_collision();
    t_open_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule